// File: doc/BRIEF.md
# Passive-Serial FPGA Configuration Master

This block loads a configuration bitstream into a target FPGA over a passive-serial link. The host pulses `start` with the total number of bytes on `byte_count`. The block then drives the target's program-request line low for a fixed hold time and checks that the target acknowledges by pulling its status line low. It releases the request, waits a settle time and then polls until the target releases its status line. The poll gives up after a timeout.

Bytes arrive on a byte-wide ready/valid stream. Each byte is shifted out least-significant bit first on a data pin, with a serial clock whose levels each last a whole number of system cycles set by a divider parameter. Data changes only while the serial clock is low, and the target samples it on the rising edge. After the last byte, the block requires the target's configuration-complete input to be high. It then issues 12 extra clock pulses so the target can finish its start-up.

The host sees `busy` for the whole sequence and then either `done` or `error` with a 2-bit reason code. An `abort` input stops a sequence at any point and returns the pins to idle.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset the target pins are idle: `tgt_prog_n` high, `tgt_clk` low and `tgt_dat` low. `busy`, `done`, `error` and `s_ready` are all low. Whenever `busy` is low, `tgt_prog_n` is high and `tgt_clk` is low.
- R2: When `start` is seen while idle, `tgt_prog_n` is driven low for exactly `HOLD_CYC` cycles, and `tgt_clk` stays low during that time. A `start` seen while `busy` is high is ignored.
- R3: If the synchronised `tgt_stat_n` is still high at the end of the hold time, the sequence ends with `error` and `err_code` = 2'b01.
- R4: After `tgt_prog_n` is released, the block waits `WAIT_CYC` cycles and then polls `tgt_stat_n`. If that input is not high within `TIMEOUT_CYC` polling cycles, the sequence ends with `error` and `err_code` = 2'b10, about `WAIT_CYC + TIMEOUT_CYC` cycles after the release.
- R5: Each byte produces 8 rising edges of `tgt_clk`, with bit 0 presented first and bit 7 last. `tgt_dat` changes only while `tgt_clk` is low, and it is stable across every rising edge.
- R6: Outside an abort, every high or low level of `tgt_clk` lasts at least `HALF_CYC` system cycles.
- R7: `s_ready` is high only while data is being loaded, the serialiser is empty and bytes remain. Exactly `byte_count` bytes are accepted per sequence.
- R8: If `tgt_cfg_ok` is low after the last byte, the sequence ends with `error` and `err_code` = 2'b11, and no further clock pulses are issued.
- R9: If `tgt_cfg_ok` is high after the last byte, exactly 12 further `tgt_clk` pulses are issued, and then `done` rises with `error` low.
- R10: `abort` while `busy` ends the sequence on the next cycle with `error` high, `err_code` = 2'b00, `busy` low and the pins idle.
- R11: A `byte_count` of zero skips data loading and goes directly to the configuration-complete check and the trailing pulses.
- R12: `busy` rises on the cycle after an accepted start. `done` and `error` are never high together, and each holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a configuration sequence (honoured only when idle) |
| abort | input | 1 | Stop the running sequence |
| byte_count | input | LEN_W | Number of bitstream bytes, sampled on start |
| s_data | input | 8 | Stream byte |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Block accepts the stream byte this cycle |
| tgt_prog_n | output | 1 | Program request to the target, active low |
| tgt_clk | output | 1 | Serial configuration clock |
| tgt_dat | output | 1 | Serial configuration data |
| tgt_stat_n | input | 1 | Target status, low while the target is held in reset |
| tgt_cfg_ok | input | 1 | Target reports configuration complete |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence completed successfully |
| error | output | 1 | Last sequence failed or was aborted |
| err_code | output | 2 | 00 abort, 01 no status acknowledge, 10 status release timeout, 11 configuration not complete |

## Verification
Some rules are checked on every cycle: idle pins whenever the block is not busy, a quiet serial clock while the program request is low, data moving only on a low clock and steady at each rise, the minimum level length of the clock, ready only while busy, the abort response, and the exclusive, sticky status flags. A target model in the bench shows the rest. It rebuilds bytes from the rising edges to confirm LSB-first order, counts the trailing pulses and the handshakes, and measures the hold time and the timeout delay. Only scenarios can show the three failure responses of the target (no acknowledge, no release, no completion) and a zero-length load.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef enum logic [1:0] {
    ERR_ABORT   = 2'd0,
    ERR_NOSTAT  = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_NODONE  = 2'd3
  } err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_SETTLE,
    ST_POLL,
    ST_LOAD,
    ST_CHECK,
    ST_TRAIL
  } st_e;

endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] r;

  always_ff @(posedge clk) begin
    if (rst) r <= {STAGES{RST_VAL}};
    else     r <= {r[STAGES-2:0], d};
  end

  assign q = r[STAGES-1];
endmodule

// File: rtl/ps_tick.sv
module ps_tick #(
  parameter int HALF = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ps_shift.sv
module ps_shift #(
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic          ld,
  input  logic          ld_pad,
  input  logic [BW-1:0] ld_bits,
  input  logic [7:0]    ld_byte,
  output logic          empty,
  output logic          dclk,
  output logic          dat
);
  logic [BW-1:0] left;
  logic          phase;
  logic          pad;
  logic [7:0]    sreg;

  assign empty = (left == '0);
  assign dat   = sreg[0];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      left  <= '0;
      phase <= 1'b0;
      pad   <= 1'b0;
      sreg  <= '0;
      dclk  <= 1'b0;
    end else if (ld && empty) begin
      left  <= ld_bits;
      phase <= 1'b0;
      pad   <= ld_pad;
      dclk  <= 1'b0;
      if (!ld_pad) sreg <= ld_byte;
    end else if (tick && !empty) begin
      if (!phase) begin
        dclk  <= 1'b1;
        phase <= 1'b1;
      end else begin
        dclk  <= 1'b0;
        phase <= 1'b0;
        left  <= left - 1'b1;
        if (!pad) sreg <= {1'b0, sreg[7:1]};
      end
    end
  end
endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
  import ps_cfg_pkg::*;
#(
  parameter int CLK_HZ       = 100_000_000,
  parameter int LEN_W        = 24,
  parameter int HALF_CYC     = (CLK_HZ + 99_999_999) / 100_000_000,
  parameter int HOLD_CYC     = CLK_HZ / 500_000 + 1,
  parameter int WAIT_CYC     = CLK_HZ / 500_000 + 1,
  parameter int TIMEOUT_CYC  = CLK_HZ / 10,
  parameter int TRAIL_PULSES = 12,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             abort,
  input  logic [LEN_W-1:0] byte_count,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  output logic             s_ready,
  output logic             tgt_prog_n,
  output logic             tgt_clk,
  output logic             tgt_dat,
  input  logic             tgt_stat_n,
  input  logic             tgt_cfg_ok,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [1:0]       err_code
);
  localparam int CHK_CYC = SYNC_STAGES + 2;
  localparam int M1      = (HOLD_CYC > WAIT_CYC) ? HOLD_CYC : WAIT_CYC;
  localparam int M2      = (M1 > TIMEOUT_CYC) ? M1 : TIMEOUT_CYC;
  localparam int TMR_MAX = (M2 > CHK_CYC) ? M2 : CHK_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int BITS_MX = (TRAIL_PULSES > 8) ? TRAIL_PULSES : 8;
  localparam int BW      = $clog2(BITS_MX + 1);

  localparam logic [TMR_W-1:0] HOLD_END = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] WAIT_END = TMR_W'(WAIT_CYC - 1);
  localparam logic [TMR_W-1:0] TMO_END  = TMR_W'(TIMEOUT_CYC - 1);
  localparam logic [TMR_W-1:0] CHK_END  = TMR_W'(CHK_CYC - 1);

  st_e              state;
  logic [TMR_W-1:0] tmr;
  logic [LEN_W-1:0] remain;
  logic             prog_n_q, busy_q, done_q, err_q;
  err_e             code_q;

  logic stat_s, ok_s;
  logic sh_empty, sh_tick, sh_ld, sh_pad, sh_clr, take, trail_ld;

  ps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_stat (
    .clk(clk), .rst(rst), .d(tgt_stat_n), .q(stat_s));
  ps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_ok (
    .clk(clk), .rst(rst), .d(tgt_cfg_ok), .q(ok_s));

  assign s_ready  = (state == ST_LOAD) && sh_empty && (remain != '0);
  assign take     = s_valid && s_ready;
  assign trail_ld = (state == ST_CHECK) && (tmr == CHK_END) && ok_s;
  assign sh_ld    = take || trail_ld;
  assign sh_pad   = (state == ST_CHECK);
  assign sh_clr   = busy_q && abort;

  ps_tick #(.HALF(HALF_CYC)) u_tick (
    .clk(clk), .rst(rst), .en(!sh_empty), .tick(sh_tick));

  ps_shift #(.BW(BW)) u_shift (
    .clk(clk), .rst(rst), .clr(sh_clr), .tick(sh_tick),
    .ld(sh_ld), .ld_pad(sh_pad),
    .ld_bits(sh_pad ? BW'(TRAIL_PULSES) : BW'(8)),
    .ld_byte(s_data), .empty(sh_empty), .dclk(tgt_clk), .dat(tgt_dat));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      tmr      <= '0;
      remain   <= '0;
      prog_n_q <= 1'b1;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      code_q   <= ERR_ABORT;
    end else if (busy_q && abort) begin
      state    <= ST_IDLE;
      prog_n_q <= 1'b1;
      busy_q   <= 1'b0;
      err_q    <= 1'b1;
      code_q   <= ERR_ABORT;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          busy_q   <= 1'b1;
          done_q   <= 1'b0;
          err_q    <= 1'b0;
          prog_n_q <= 1'b0;
          tmr      <= '0;
          remain   <= byte_count;
          state    <= ST_HOLD;
        end
        ST_HOLD: if (tmr == HOLD_END) begin
          if (stat_s) begin
            state    <= ST_IDLE;
            prog_n_q <= 1'b1;
            busy_q   <= 1'b0;
            err_q    <= 1'b1;
            code_q   <= ERR_NOSTAT;
          end else begin
            prog_n_q <= 1'b1;
            tmr      <= '0;
            state    <= ST_SETTLE;
          end
        end else tmr <= tmr + 1'b1;
        ST_SETTLE: if (tmr == WAIT_END) begin
          tmr   <= '0;
          state <= ST_POLL;
        end else tmr <= tmr + 1'b1;
        ST_POLL: if (stat_s) begin
          state <= ST_LOAD;
        end else if (tmr == TMO_END) begin
          state  <= ST_IDLE;
          busy_q <= 1'b0;
          err_q  <= 1'b1;
          code_q <= ERR_TIMEOUT;
        end else tmr <= tmr + 1'b1;
        ST_LOAD: if (take) begin
          remain <= remain - 1'b1;
        end else if (sh_empty && remain == '0) begin
          tmr   <= '0;
          state <= ST_CHECK;
        end
        ST_CHECK: if (tmr == CHK_END) begin
          if (ok_s) state <= ST_TRAIL;
          else begin
            state  <= ST_IDLE;
            busy_q <= 1'b0;
            err_q  <= 1'b1;
            code_q <= ERR_NODONE;
          end
        end else tmr <= tmr + 1'b1;
        ST_TRAIL: if (sh_empty) begin
          state  <= ST_IDLE;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tgt_prog_n = prog_n_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign error      = err_q;
  assign err_code   = code_q;
endmodule

// File: rtl/ps_cfg_master_chk.sv
module ps_cfg_master_chk #(
  parameter int HALF_CYC = 1
) (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       abort,
  input logic       s_ready,
  input logic       tgt_prog_n,
  input logic       tgt_clk,
  input logic       tgt_dat,
  input logic       busy,
  input logic       done,
  input logic       error,
  input logic [1:0] err_code
);
  logic [15:0] held_q;
  logic        last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b0;
      held_q <= 16'hFFFF;
    end else begin
      last_q <= tgt_clk;
      if (tgt_clk != last_q)    held_q <= 16'd1;
      else if (held_q != 16'hFFFF) held_q <= held_q + 16'd1;
    end
  end

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (tgt_prog_n && !tgt_clk));

  p_clk_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !tgt_prog_n |-> !tgt_clk);

  p_data_move_low_r5: assert property (@(posedge clk) disable iff (rst)
    $changed(tgt_dat) |-> !tgt_clk);

  p_data_hold_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(tgt_clk) |-> $stable(tgt_dat));

  p_level_min_r6: assert property (@(posedge clk) disable iff (rst)
    ($changed(tgt_clk) && !$past(abort)) |-> (held_q >= 16'(HALF_CYC)));

  p_ready_busy_r7: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> (busy && tgt_prog_n && !tgt_clk));

  p_abort_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && abort) |=> (error && !busy && err_code == 2'b00));

  p_start_busy_r12: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_flags_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(done && error));

  p_done_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
endmodule

bind ps_cfg_master ps_cfg_master_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk(clk), .rst(rst), .start(start), .abort(abort), .s_ready(s_ready),
  .tgt_prog_n(tgt_prog_n), .tgt_clk(tgt_clk), .tgt_dat(tgt_dat),
  .busy(busy), .done(done), .error(error), .err_code(err_code));

// File: tb/ps_cfg_master_tb_top.sv
`timescale 1ns/1ps
module ps_cfg_master_tb_top;
  localparam int HALF = 2, HOLD = 10, WAITC = 6, TMO = 300, LEN_W = 16, REL_DLY = 20;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic start = 0, abort = 0, s_valid = 0;
  logic [LEN_W-1:0] byte_count = '0;
  logic [7:0] s_data = '0;
  logic s_ready, tgt_prog_n, tgt_clk, tgt_dat, busy, done, error;
  logic [1:0] err_code;
  logic tgt_stat_n = 1'b1, tgt_cfg_ok = 1'b0;

  ps_cfg_master #(.LEN_W(LEN_W), .HALF_CYC(HALF), .HOLD_CYC(HOLD),
                  .WAIT_CYC(WAITC), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst(rst), .start(start), .abort(abort), .byte_count(byte_count),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .tgt_prog_n(tgt_prog_n), .tgt_clk(tgt_clk), .tgt_dat(tgt_dat),
    .tgt_stat_n(tgt_stat_n), .tgt_cfg_ok(tgt_cfg_ok),
    .busy(busy), .done(done), .error(error), .err_code(err_code));

  int checks = 0, errors = 0;
  // target model: 0 normal, 1 no acknowledge, 2 never releases, 3 never completes
  int mode = 0, low_cnt = 0, fall_cnt = 0, rel_cnt = 0, rx_bits = 0, trail_cnt = 0;
  int poll_cnt = 0, min_level = 0, level_len = 0, exp_bits = 0, hands = 0;
  logic [7:0] rx_mem [0:63];
  logic [7:0] tx_mem [0:63];
  logic prev_prog = 1'b1, prev_clk = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      tgt_stat_n = 1'b1; tgt_cfg_ok = 1'b0; prev_prog = 1'b1; prev_clk = 1'b0;
    end else begin
      if (!tgt_prog_n) begin
        if (prev_prog) begin
          fall_cnt++; low_cnt = 0; rx_bits = 0; trail_cnt = 0; rel_cnt = 0; poll_cnt = 0;
        end
        low_cnt++;
        tgt_stat_n = (mode == 1);
        tgt_cfg_ok = 1'b0;
      end else begin
        if (busy) poll_cnt++;
        if (!tgt_stat_n && mode != 2) begin
          rel_cnt++;
          if (rel_cnt >= REL_DLY) tgt_stat_n = 1'b1;
        end
        if (tgt_clk && !prev_clk) begin
          if (rx_bits < exp_bits) begin
            rx_mem[rx_bits/8][rx_bits%8] = tgt_dat;
            rx_bits++;
          end else trail_cnt++;
        end
        tgt_cfg_ok = (rx_bits >= exp_bits) && (mode != 3);
      end
      if (tgt_clk != prev_clk) begin
        if (level_len < min_level) min_level = level_len;
        level_len = 1;
      end else level_len++;
      prev_prog = tgt_prog_n;
      prev_clk  = tgt_clk;
    end
  end

  task automatic run(input int n, input int md, input int abort_at, input bit dup, input bit fill);
    int idx = 0, cyc = 0;
    bit acc;
    if (fill) for (int i = 0; i < n; i++) tx_mem[i] = 8'($urandom);
    mode = md; exp_bits = n * 8; fall_cnt = 0;
    min_level = 1000000; level_len = 1000000;
    @(negedge clk);
    byte_count = LEN_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && cyc < 50000) begin
      s_valid = (idx < n) && ($urandom % 4 != 0);
      s_data  = tx_mem[idx];
      acc = s_valid && s_ready;
      start = dup && (cyc == 40);
      if (abort_at > 0 && rx_bits >= abort_at) abort = 1'b1;
      @(negedge clk);
      abort = 1'b0; start = 1'b0;
      if (acc) idx++;
      cyc++;
    end
    s_valid = 1'b0;
    hands = idx;
  endtask

  task automatic check_ok(input int n, input string tag);
    bit same = 1;
    for (int i = 0; i < n; i++) if (rx_mem[i] != tx_mem[i]) same = 0;
    chk(done && !error, {"R9 done ", tag}, done, 1);
    chk(same && rx_bits == n * 8, {"R5 LSB-first bytes ", tag}, rx_bits, n * 8);
    chk(trail_cnt == 12, {"R9 trailing pulses ", tag}, trail_cnt, 12);
    chk(hands == n, {"R7 handshakes ", tag}, hands, n);
    chk(low_cnt == HOLD && fall_cnt == 1, {"R2 hold length ", tag}, low_cnt, HOLD);
    chk(min_level >= HALF, {"R6 clock level ", tag}, min_level, HALF);
  endtask

  initial begin
    void'($urandom(32'h5EED_C0DE));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !error && !s_ready, "R1 reset flags", {busy, done, error, s_ready}, 0);
    chk(tgt_prog_n && !tgt_clk && !tgt_dat, "R1 reset pins", {tgt_prog_n, tgt_clk, tgt_dat}, 4);

    // directed boundary bit patterns
    tx_mem[0] = 8'h01; tx_mem[1] = 8'h80; tx_mem[2] = 8'hA5;
    run(3, 0, 0, 0, 0);
    check_ok(3, "directed");
    repeat (5) @(negedge clk);
    chk(done && !busy, "R12 done held", done, 1);

    for (int k = 0; k < 6; k++) begin
      int n = 1 + int'($urandom % 24);
      run(n, 0, 0, 0, 1);
      check_ok(n, "random");
    end

    // R11 zero length
    run(0, 0, 0, 0, 1);
    chk(done && !error && rx_bits == 0, "R11 zero length done", rx_bits, 0);
    chk(trail_cnt == 12, "R11 zero length trailing", trail_cnt, 12);

    // R3 no acknowledge
    run(4, 1, 0, 0, 1);
    chk(error && err_code == 2'b01 && !done, "R3 no status code", err_code, 1);
    chk(hands == 0 && rx_bits == 0 && tgt_prog_n, "R3 nothing sent", rx_bits, 0);

    // R12 a good run clears the error
    run(2, 0, 0, 0, 1);
    chk(!error && done, "R12 error cleared by start", error, 0);

    // R4 release timeout
    run(4, 2, 0, 0, 1);
    chk(error && err_code == 2'b10, "R4 timeout code", err_code, 2);
    chk(poll_cnt >= WAITC + TMO - 1 && poll_cnt <= WAITC + TMO + 1, "R4 timeout delay",
        poll_cnt, WAITC + TMO);

    // R8 configuration never completes
    run(5, 3, 0, 0, 1);
    chk(error && err_code == 2'b11, "R8 no done code", err_code, 3);
    chk(rx_bits == 40 && trail_cnt == 0, "R8 no trailing pulses", trail_cnt, 0);

    // R10 abort mid-load
    run(16, 0, 20, 0, 1);
    chk(error && err_code == 2'b00 && !busy, "R10 abort code", err_code, 0);
    chk(tgt_prog_n && !tgt_clk && rx_bits < 128, "R10 pins idle", rx_bits, 20);

    // R2 start while busy is ignored
    run(6, 0, 0, 1, 1);
    check_ok(6, "dup start");
    chk(fall_cnt == 1, "R2 start ignored when busy", fall_cnt, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule